// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets an external host reach a bank of byte-wide registers over three signals: an active-high chip enable, a serial clock and a serial data input. The block answers on a serial data output with its own output enable, so that a pad can tri-state it and the output can be joined to the input to form one bidirectional data wire. The serial clock is brought into a faster system clock domain through a synchroniser and edge detector. Chip enable, data input and the register bank interface are already in the system clock domain.

A transaction is everything between chip enable going high and going low again. The first byte in the window is a command. Its top bit selects read (1) or write (0), bits 6 to 4 are ignored, and the low four bits give the first register address. Every later byte is data. A write byte is committed once all eight bits have arrived. A read byte is fetched from the register bank before its first bit is due. After each data byte the address steps by one and wraps from the last register to register 0.

Top module: `serreg_slave`

## Requirements
- R1: While chip enable is low, and after reset, `sdo_oe_o` and `sdo_o` are 0 and no register write is issued.
- R2: Bytes move most significant bit first in both directions: bit 7 is sampled at the first rising serial clock edge of a byte, and bit 7 of read data is presented first.
- R3: The command byte is decoded as bit 7 = direction (1 read, 0 write) and bits 3:0 = start address; bits 6:4 have no effect.
- R4: In write mode each complete data byte is written with one `reg_we_o` pulse to the current address, and the address then steps by one.
- R5: The address wraps from 15 to 0, for both writes and reads.
- R6: In read mode the register at the current address is loaded at the falling serial clock edge that ends the previous byte, so its bit 7 is valid before the next rising edge; later bytes come from successive addresses.
- R7: `sdo_oe_o` stays low during the command byte and throughout a write transaction, and is high for every data bit of a read transaction.
- R8: A data byte cut short by chip enable going low is not written, and the next transaction begins again with a command byte.
- R9: Input data is taken at rising serial clock edges; `sdo_o` changes only after falling edges and stays stable while the serial clock is high.
- R10: In read mode the data input has no effect: no register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_i | input | 1 | Active-high chip enable; low resets the interface |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| reg_addr_o | output | 4 | Register bank address for both read and write |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, combinational |

## Verification
A wrong bit counter shows as a write to the wrong register or with rotated data, seen in the register bank at the end of the same byte. A wrong address pointer shows as read data from the wrong register on the next byte, most visibly across the 15 to 0 wrap. If the direction or phase flag is wrong, the output enable is asserted during the command byte or during writes. A state that survives chip enable going low shows up in the first byte of the next transaction. The bench records the output and output enable just before every rising edge and again during the high phase, so a stray output change is caught within the bit in which it happens.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CMD_DIR_BIT = 7;

  typedef enum logic {
    XFER_WRITE = 1'b0,
    XFER_READ  = 1'b1
  } xfer_dir_e;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  function automatic xfer_dir_e cmd_dir(input logic [BYTE_W-1:0] cmd);
    return xfer_dir_e'(cmd[CMD_DIR_BIT]);
  endfunction

endpackage

// File: rtl/serreg_edge_sync.sv
module serreg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  // chain_q[0..STAGES-1] synchronise; chain_q[STAGES] holds the previous level
  generate
    for (genvar g = 0; g < CHAIN_W; g++) begin : g_chain
      if (g == 0) begin : g_head
        assign chain_d[g] = sclk_i;
      end else begin : g_body
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/serreg_rx_ctrl.sv
module serreg_rx_ctrl
  import serreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              din_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_mode_o,
  output logic              rd_load_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  phase_e            phase_q, phase_d;
  xfer_dir_e         dir_q,   dir_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [BYTE_W-1:0] rx_q,    rx_d;
  logic              done_q,  done_d;

  logic [BYTE_W-1:0] byte_full;
  logic              last_bit;

  assign byte_full = {rx_q[BYTE_W-2:0], din_i};
  assign last_bit  = (cnt_q == LAST_BIT);

  always_comb begin
    cnt_d     = cnt_q;
    phase_d   = phase_q;
    dir_d     = dir_q;
    addr_d    = addr_q;
    rx_d      = rx_q;
    done_d    = done_q;
    wr_en_o   = 1'b0;
    rd_load_o = 1'b0;
    if (!ce_i) begin
      cnt_d   = '0;
      phase_d = PH_CMD;
      dir_d   = XFER_WRITE;
      addr_d  = '0;
      rx_d    = '0;
      done_d  = 1'b0;
    end else begin
      if (rise_i) begin
        rx_d   = byte_full;
        cnt_d  = last_bit ? '0 : cnt_q + 1'b1;
        done_d = last_bit;
        if (last_bit) begin
          if (phase_q == PH_CMD) begin
            phase_d = PH_DATA;
            dir_d   = cmd_dir(byte_full);
            addr_d  = byte_full[ADDR_W-1:0];
          end else if (dir_q == XFER_WRITE) begin
            wr_en_o = 1'b1;
            addr_d  = addr_q + 1'b1;
          end
        end
      end
      if (fall_i && done_q) begin
        done_d = 1'b0;
        if (dir_q == XFER_READ) begin
          rd_load_o = 1'b1;
          addr_d    = addr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_CMD;
      dir_q   <= XFER_WRITE;
      addr_q  <= '0;
      rx_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      dir_q   <= dir_d;
      addr_q  <= addr_d;
      rx_q    <= rx_d;
      done_q  <= done_d;
    end
  end

  assign addr_o    = addr_q;
  assign wr_data_o = byte_full;
  assign rd_mode_o = (phase_q == PH_DATA) && (dir_q == XFER_READ);

  // R4: a committed write moves the pointer to the next register
  p_write_advances_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o ##1 ce_i |-> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  // R8: chip enable low returns the byte framing to the command phase
  p_ce_resets_framing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (cnt_q == '0) && (phase_q == PH_CMD) && !done_q);

endmodule

// File: rtl/serreg_tx.sv
module serreg_tx
  import serreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              fall_i,
  input  logic              rd_load_i,
  input  logic              rd_mode_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              oe_q,    oe_d;

  always_comb begin
    shift_d = shift_q;
    oe_d    = oe_q;
    if (!ce_i) begin
      shift_d = '0;
      oe_d    = 1'b0;
    end else if (rd_load_i) begin
      shift_d = rdata_i;
      oe_d    = 1'b1;
    end else if (fall_i && oe_q) begin
      shift_d = {shift_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      shift_q <= shift_d;
      oe_q    <= oe_d;
    end
  end

  assign sdo_o    = oe_q & shift_q[BYTE_W-1];
  assign sdo_oe_o = oe_q;

  // R7: the pad is driven only once a read transaction is decoded
  p_oe_needs_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> rd_mode_i);

  // R6: a fetch captures the bank data and enables the pad
  p_load_captures_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i && ce_i |=> oe_q && (shift_q == $past(rdata_i)));

  // R1: chip enable low releases the pad
  p_ce_low_tristate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !oe_q && !sdo_o);

  // R9: the output bit only moves on a falling serial clock edge
  p_shift_on_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !fall_i && !rd_load_i |=> $stable(shift_q));

endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
  import serreg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);

  logic sclk_rise;
  logic sclk_fall;
  logic rd_mode;
  logic rd_load;

  serreg_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  serreg_rx_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_i),
    .din_i     (sdi_i),
    .rise_i    (sclk_rise),
    .fall_i    (sclk_fall),
    .addr_o    (reg_addr_o),
    .wr_en_o   (reg_we_o),
    .wr_data_o (reg_wdata_o),
    .rd_mode_o (rd_mode),
    .rd_load_o (rd_load)
  );

  serreg_tx u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_i),
    .fall_i    (sclk_fall),
    .rd_load_i (rd_load),
    .rd_mode_i (rd_mode),
    .rdata_i   (reg_rdata_i),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o)
  );

  // R1: no write strobe leaves the block while deselected
  p_no_write_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ce_i);

  // R10: writes and read fetches never overlap in one transaction
  p_no_write_in_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !sdo_oe_o);

endmodule

// File: tb/serreg_slave_tb_top.sv
module serreg_slave_tb_top;

  localparam int HP = 8;

  logic       clk;
  logic       rst_n;
  logic       ce;
  logic       sclk;
  logic       sdi;
  logic       sdo;
  logic       sdo_oe;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;

  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];
  int         we_cnt;
  int         checks;
  int         failures;
  logic       done;

  serreg_slave dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ce_i        (ce),
    .sclk_i      (sclk),
    .sdi_i       (sdi),
    .sdo_o       (sdo),
    .sdo_oe_o    (sdo_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // register bank model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'(i * 17) ^ 8'h5A;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_cnt <= 0;
    else if (reg_we) we_cnt <= we_cnt + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sclk_bit(input logic b, output logic got, output logic oe_seen,
                          output logic stable_ok);
    sdi = b;
    repeat (HP) @(negedge clk);
    got     = sdo;
    oe_seen = sdo_oe;
    sclk = 1'b1;
    repeat (HP / 2) @(negedge clk);
    stable_ok = (sdo === got) && (sdo_oe === oe_seen);
    repeat (HP - HP / 2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q,
                      output int oe_bits, output logic stable_all);
    oe_bits    = 0;
    stable_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic g, o, s;
      sclk_bit(d[i], g, o, s);
      q[i] = g;
      if (o) oe_bits++;
      if (!s) stable_all = 1'b0;
    end
  endtask

  task automatic start_xfer();
    ce = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic stop_xfer();
    repeat (HP) @(negedge clk);
    ce  = 1'b0;
    sdi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "oe after reset", 32'(sdo_oe), 0);
    chk("R1", "sdo after reset", 32'(sdo), 0);
    chk("R1", "writes after reset", we_cnt, 0);
  endtask

  task automatic t_write_burst();
    logic [7:0] q; int oe; logic st; int w0;
    logic [7:0] dat [3];
    dat[0] = 8'hA5; dat[1] = 8'h3C; dat[2] = 8'hF0;
    w0 = we_cnt;
    start_xfer();
    xfer(8'h02, q, oe, st);
    chk("R7", "oe during write command", oe, 0);
    for (int k = 0; k < 3; k++) begin
      xfer(dat[k], q, oe, st);
      chk("R7", "oe during write data", oe, 0);
      exp_mem[2 + k] = dat[k];
    end
    stop_xfer();
    for (int k = 0; k < 3; k++) chk("R2", "written byte MSB first", mem[2 + k], exp_mem[2 + k]);
    chk("R4", "one strobe per byte", we_cnt - w0, 3);
  endtask

  task automatic t_read_burst();
    logic [7:0] q; int oe; logic st; int w0;
    w0 = we_cnt;
    start_xfer();
    xfer(8'h82, q, oe, st);
    chk("R7", "oe during read command", oe, 0);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, q, oe, st);
      chk("R6", "read data", q, exp_mem[2 + k]);
      chk("R7", "oe on read bits", oe, 8);
      chk("R9", "sdo stable while sclk high", 32'(st), 1);
    end
    stop_xfer();
    chk("R10", "no writes in read", we_cnt - w0, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] q; int oe; logic st;
    logic [7:0] dat [4];
    dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33; dat[3] = 8'h44;
    start_xfer();
    xfer(8'h0E, q, oe, st);
    for (int k = 0; k < 4; k++) begin
      xfer(dat[k], q, oe, st);
      exp_mem[(14 + k) % 16] = dat[k];
    end
    stop_xfer();
    chk("R5", "write reg 15", mem[15], 8'h22);
    chk("R5", "write wraps to reg 0", mem[0], 8'h33);
    chk("R5", "write reg 1", mem[1], 8'h44);
    start_xfer();
    xfer(8'hFF, q, oe, st);
    xfer(8'h00, q, oe, st);
    chk("R3", "read cmd with reserved bits set", q, exp_mem[15]);
    xfer(8'h00, q, oe, st);
    chk("R5", "read wraps to reg 0", q, exp_mem[0]);
    xfer(8'h00, q, oe, st);
    chk("R5", "read reg 1 after wrap", q, exp_mem[1]);
    stop_xfer();
  endtask

  task automatic t_reserved_write();
    logic [7:0] q; int oe; logic st;
    start_xfer();
    xfer(8'h75, q, oe, st);
    xfer(8'h6B, q, oe, st);
    chk("R3", "write cmd with reserved bits", oe, 0);
    stop_xfer();
    exp_mem[5] = 8'h6B;
    chk("R3", "reserved bits ignored on write", mem[5], exp_mem[5]);
  endtask

  task automatic t_partial();
    logic [7:0] q; int oe; logic st; int w0;
    logic g, o, s;
    w0 = we_cnt;
    start_xfer();
    xfer(8'h07, q, oe, st);
    xfer(8'h9C, q, oe, st);
    exp_mem[7] = 8'h9C;
    for (int i = 0; i < 5; i++) sclk_bit(1'b1, g, o, s);
    stop_xfer();
    chk("R8", "full byte kept", mem[7], exp_mem[7]);
    chk("R8", "partial byte dropped", mem[8], exp_mem[8]);
    chk("R8", "strobe count", we_cnt - w0, 1);
    start_xfer();
    xfer(8'h88, q, oe, st);
    chk("R8", "new command after abort, oe", oe, 0);
    xfer(8'h00, q, oe, st);
    chk("R8", "new command after abort, data", q, exp_mem[8]);
    stop_xfer();
  endtask

  task automatic t_read_ignore();
    logic [7:0] q; int oe; logic st; int w0;
    w0 = we_cnt;
    start_xfer();
    xfer(8'h83, q, oe, st);
    xfer(8'hFF, q, oe, st);
    chk("R10", "read with ones on input", q, exp_mem[3]);
    xfer(8'h5A, q, oe, st);
    chk("R10", "read with pattern on input", q, exp_mem[4]);
    stop_xfer();
    chk("R10", "no strobes", we_cnt - w0, 0);
    chk("R10", "reg 3 unchanged", mem[3], exp_mem[3]);
    chk("R10", "reg 4 unchanged", mem[4], exp_mem[4]);
    chk("R1", "oe after deselect", 32'(sdo_oe), 0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; ce = 1'b0; sclk = 1'b0; sdi = 1'b0;
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'(i * 17) ^ 8'h5A;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_wrap();
    t_reserved_write();
    t_partial();
    t_read_ignore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule